// File: doc/BRIEF.md
# SPI Master Serial Clock and Framing Delay Generator

This block produces the serial clock of a master SPI port, together with the three framing delays around each frame. The delays are the wait from chip-select assertion to the first clock edge, the wait from the last clock edge to chip-select release, and the idle gap after release before another frame may start. It runs from the system clock. Each of the four timings comes from a short prescaler code and a scaler code. A double-rate option halves the bit period. A 2-bit code delays the receive sample strobe by a few system clocks after the capturing edge.

A sequencer pulses `start` to begin a frame. The generator samples every attribute input and the frame length in that cycle and then runs the whole frame unattended. Along the way it drives the serial clock, a chip-select-active level, shift and sample strobes for an external shift register, and a one-cycle completion pulse for each phase. While a frame is running, `start` and attribute changes have no effect.

Top module: `spi_timing_gen`

## Requirements
- R1: With double rate off, one bit lasts P × 2^(n+1) system clocks. P is 2, 3, 5 or 7 for baud prescaler code 0, 1, 2 or 3, and n is the 4-bit baud scaler code.
- R2: With double rate on, one bit lasts P × 2^n clocks. Within each bit the active clock level lasts floor(T/2) clocks and the idle level lasts the rest, so the active level is one clock shorter when T is odd.
- R3: Each of the three delays lasts Q × 2^(m+1) clocks. Q is 1, 3, 5 or 7 for its prescaler code 0 to 3, and m is its 4-bit scaler code.
- R4: An accepted start raises `cs_act` and `busy` in the next cycle. The phases then run in this order: lead delay, bit clocks, trail delay (with `cs_act` still high), and gap delay (with `cs_act` low and `busy` high). After that both signals are low.
- R5: The serial clock rests at `cpol` outside the active half of each bit and is the inverse of `cpol` during it.
- R6: The leading edge opens each bit and the trailing edge falls after the active half. With `cpha`=0, `sample_stb` aligns with leading edges and `shift_stb` with trailing edges. With `cpha`=1 the two swap. Each strobe is high in the same cycle as the `sck` change.
- R7: `sample_stb` follows the capturing edge by 0, 1 or 2 clocks for `smpl_dly` code 0, 1 or 2. Code 3 behaves like code 0.
- R8: `lead_done`, `bits_done`, `trail_done` and `gap_done` each pulse for one cycle, in the first cycle after their phase ends. At most one of them is high in any cycle.
- R9: While `busy` is high, `start` is ignored, and changes to the attribute inputs and `frame_len` do not alter the running frame.
- R10: A frame carries `frame_len`+1 bit clocks.
- R11: After reset the block is idle: `sck`, `cs_act`, `busy`, every strobe and every done pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| frame_len | input | FLEN_W | Number of bits minus one |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Edge selection for shift and sample |
| dbr | input | 1 | Double-rate enable |
| baud_pre | input | 2 | Baud prescaler code |
| baud_scl | input | 4 | Baud scaler code |
| lead_pre | input | 2 | Chip-select-to-clock delay prescaler code |
| lead_scl | input | 4 | Chip-select-to-clock delay scaler code |
| trail_pre | input | 2 | After-clock delay prescaler code |
| trail_scl | input | 4 | After-clock delay scaler code |
| gap_pre | input | 2 | After-transfer delay prescaler code |
| gap_scl | input | 4 | After-transfer delay scaler code |
| smpl_dly | input | 2 | Receive sample delay code |
| sck | output | 1 | Serial clock |
| cs_act | output | 1 | Chip select should be asserted |
| busy | output | 1 | Frame in progress |
| shift_stb | output | 1 | Change transmit data now |
| sample_stb | output | 1 | Capture receive data now |
| lead_done | output | 1 | Lead delay finished |
| bits_done | output | 1 | Bit clocks finished |
| trail_done | output | 1 | Trail delay finished |
| gap_done | output | 1 | Gap delay finished |

## Verification
Two functions can land in the same cycle. The delayed sample strobe can fall on a cycle that already carries a shift strobe or a phase-done pulse. With `cpha`=0 and a one-clock active half, a one-clock sample delay places `sample_stb` on the trailing edge together with `shift_stb`. With `cpha`=1 and a short idle half, the last delayed sample can fall on the `bits_done` cycle or inside the trail delay. The sweep covers every sample code with every prescaler, with and without double rate, so these overlaps occur many times. Every cycle of every frame is compared with a timeline built from the lengths the requirements give, so an overlapped strobe that is lost or moved shows up as a mismatch.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

    localparam int unsigned SCL_W   = 4;
    localparam int unsigned MAX_LEN = 7 << (1 << SCL_W);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
    localparam int unsigned N_DLY   = 3;
    localparam int unsigned DLY_LEAD  = 0;
    localparam int unsigned DLY_TRAIL = 1;
    localparam int unsigned DLY_GAP   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACT,
        ST_REST,
        ST_TRAIL,
        ST_GAP
    } tg_state_e;

    typedef struct packed {
        logic                             cpol;
        logic                             cpha;
        logic                             dbr;
        logic [1:0]                       smpl;
        logic [1:0]                       br_pre;
        logic [SCL_W-1:0]                 br_scl;
        logic [N_DLY-1:0][1:0]            d_pre;
        logic [N_DLY-1:0][SCL_W-1:0]      d_scl;
    } tg_cfg_t;

endpackage

// File: rtl/spi_tg_len.sv
module spi_tg_len
    import spi_tg_pkg::*;
#(
    parameter bit IS_BAUD = 1'b0
) (
    input  logic [1:0]       pre_i,
    input  logic [SCL_W-1:0] scl_i,
    input  logic             half_i,
    output logic [CNT_W-1:0] len_o
);

    logic [2:0]     pre_v;
    logic [SCL_W:0] shamt;

    always_comb begin
        case (pre_i)
            2'd0:    pre_v = IS_BAUD ? 3'd2 : 3'd1;
            2'd1:    pre_v = 3'd3;
            2'd2:    pre_v = 3'd5;
            default: pre_v = 3'd7;
        endcase
        shamt = {1'b0, scl_i} + (SCL_W + 1)'(1)
              - {{SCL_W{1'b0}}, (IS_BAUD && half_i)};
        len_o = CNT_W'(pre_v) << shamt;
    end

endmodule

// File: rtl/spi_tg_seq.sv
module spi_tg_seq
    import spi_tg_pkg::*;
#(
    parameter int unsigned FLEN_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [FLEN_W-1:0]           flen_i,
    input  tg_cfg_t                     cfg_i,
    input  logic [CNT_W-1:0]            per_len_i,
    input  logic [N_DLY-1:0][CNT_W-1:0] dly_len_i,
    output tg_cfg_t                     cfg_eff_o,
    output tg_cfg_t                     cfg_run_o,
    output logic                        sck_o,
    output logic                        cs_act_o,
    output logic                        busy_o,
    output logic                        lead_o,
    output logic                        trail_o,
    output logic [N_DLY:0]              done_o
);

    typedef struct packed {
        tg_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [FLEN_W-1:0]  bits;
        logic [FLEN_W-1:0]  flen;
        logic               sck;
        logic               lead;
        logic               trail;
        logic [N_DLY:0]     done;
        tg_cfg_t            cfg;
    } seq_t;

    seq_t             cur_q;
    seq_t             nxt_d;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic             cnt_zero;

    assign hi_len   = per_len_i >> 1;
    assign lo_len   = per_len_i - hi_len;
    assign cnt_zero = (cur_q.cnt == '0);

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.lead  = 1'b0;
        nxt_d.trail = 1'b0;
        nxt_d.done  = '0;
        nxt_d.cnt   = cur_q.cnt - CNT_W'(1);
        case (cur_q.st)
            ST_IDLE: begin
                nxt_d.sck = cfg_i.cpol;
                nxt_d.cnt = cur_q.cnt;
                if (start_i) begin
                    nxt_d.st   = ST_LEAD;
                    nxt_d.cfg  = cfg_i;
                    nxt_d.flen = flen_i;
                    nxt_d.bits = '0;
                    nxt_d.cnt  = dly_len_i[DLY_LEAD] - CNT_W'(1);
                end
            end
            ST_LEAD: begin
                if (cnt_zero) begin
                    nxt_d.st      = ST_ACT;
                    nxt_d.cnt     = hi_len - CNT_W'(1);
                    nxt_d.sck     = ~cur_q.cfg.cpol;
                    nxt_d.lead    = 1'b1;
                    nxt_d.done[0] = 1'b1;
                end
            end
            ST_ACT: begin
                if (cnt_zero) begin
                    nxt_d.st    = ST_REST;
                    nxt_d.cnt   = lo_len - CNT_W'(1);
                    nxt_d.sck   = cur_q.cfg.cpol;
                    nxt_d.trail = 1'b1;
                end
            end
            ST_REST: begin
                if (cnt_zero) begin
                    if (cur_q.bits == cur_q.flen) begin
                        nxt_d.st      = ST_TRAIL;
                        nxt_d.cnt     = dly_len_i[DLY_TRAIL] - CNT_W'(1);
                        nxt_d.done[1] = 1'b1;
                    end else begin
                        nxt_d.st   = ST_ACT;
                        nxt_d.bits = cur_q.bits + FLEN_W'(1);
                        nxt_d.cnt  = hi_len - CNT_W'(1);
                        nxt_d.sck  = ~cur_q.cfg.cpol;
                        nxt_d.lead = 1'b1;
                    end
                end
            end
            ST_TRAIL: begin
                if (cnt_zero) begin
                    nxt_d.st      = ST_GAP;
                    nxt_d.cnt     = dly_len_i[DLY_GAP] - CNT_W'(1);
                    nxt_d.done[2] = 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt_zero) begin
                    nxt_d.st      = ST_IDLE;
                    nxt_d.cnt     = '0;
                    nxt_d.done[3] = 1'b1;
                end
            end
            default: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cfg_eff_o = (cur_q.st == ST_IDLE) ? cfg_i : cur_q.cfg;
    assign cfg_run_o = cur_q.cfg;
    assign sck_o     = cur_q.sck;
    assign cs_act_o  = (cur_q.st == ST_LEAD) || (cur_q.st == ST_ACT) ||
                       (cur_q.st == ST_REST) || (cur_q.st == ST_TRAIL);
    assign busy_o    = (cur_q.st != ST_IDLE);
    assign lead_o    = cur_q.lead;
    assign trail_o   = cur_q.trail;
    assign done_o    = cur_q.done;

    p_sck_rest_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st inside {ST_LEAD, ST_REST, ST_TRAIL, ST_GAP}) |-> (cur_q.sck == cur_q.cfg.cpol));

    p_edges_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.lead && cur_q.trail));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cur_q.done));

    p_frame_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act_o) |-> $past(start_i));

    p_active_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_ACT) |-> (cur_q.cnt < hi_len));

    p_rest_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_REST) |-> (cur_q.cnt < lo_len));

    p_bits_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st inside {ST_ACT, ST_REST}) |-> (cur_q.bits <= cur_q.flen));

endmodule

// File: rtl/spi_tg_strobe.sv
module spi_tg_strobe (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lead_i,
    input  logic       trail_i,
    input  logic       cpha_i,
    input  logic [1:0] smpl_i,
    output logic       shift_o,
    output logic       sample_o
);

    typedef struct packed {
        logic d1;
        logic d2;
    } dly_t;

    dly_t dly_q;
    dly_t dly_d;
    logic cap;

    assign cap     = cpha_i ? trail_i : lead_i;
    assign shift_o = cpha_i ? lead_i  : trail_i;

    always_comb begin
        dly_d.d1 = cap;
        dly_d.d2 = dly_q.d1;
        case (smpl_i)
            2'd1:    sample_o = dly_q.d1;
            2'd2:    sample_o = dly_q.d2;
            default: sample_o = cap;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q <= dly_d;
        end
    end

    p_sample_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && (smpl_i == 2'd0 || smpl_i == 2'd3)) |-> sample_o);

    p_sample_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && smpl_i == 2'd1) |=> sample_o);

    p_sample_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && smpl_i == 2'd2) |=> ##1 sample_o);

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
    import spi_tg_pkg::*;
#(
    parameter int unsigned FLEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FLEN_W-1:0] frame_len,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              dbr,
    input  logic [1:0]        baud_pre,
    input  logic [SCL_W-1:0]  baud_scl,
    input  logic [1:0]        lead_pre,
    input  logic [SCL_W-1:0]  lead_scl,
    input  logic [1:0]        trail_pre,
    input  logic [SCL_W-1:0]  trail_scl,
    input  logic [1:0]        gap_pre,
    input  logic [SCL_W-1:0]  gap_scl,
    input  logic [1:0]        smpl_dly,
    output logic              sck,
    output logic              cs_act,
    output logic              busy,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              lead_done,
    output logic              bits_done,
    output logic              trail_done,
    output logic              gap_done
);

    tg_cfg_t                     cfg_in;
    tg_cfg_t                     cfg_eff;
    tg_cfg_t                     cfg_run;
    logic [CNT_W-1:0]            per_len;
    logic [N_DLY-1:0][CNT_W-1:0] dly_len;
    logic                        lead_e;
    logic                        trail_e;
    logic [N_DLY:0]              done;

    always_comb begin
        cfg_in.cpol             = cpol;
        cfg_in.cpha             = cpha;
        cfg_in.dbr              = dbr;
        cfg_in.smpl             = smpl_dly;
        cfg_in.br_pre           = baud_pre;
        cfg_in.br_scl           = baud_scl;
        cfg_in.d_pre[DLY_LEAD]  = lead_pre;
        cfg_in.d_scl[DLY_LEAD]  = lead_scl;
        cfg_in.d_pre[DLY_TRAIL] = trail_pre;
        cfg_in.d_scl[DLY_TRAIL] = trail_scl;
        cfg_in.d_pre[DLY_GAP]   = gap_pre;
        cfg_in.d_scl[DLY_GAP]   = gap_scl;
    end

    spi_tg_len #(.IS_BAUD(1'b1)) u_baud_len (
        .pre_i  (cfg_eff.br_pre),
        .scl_i  (cfg_eff.br_scl),
        .half_i (cfg_eff.dbr),
        .len_o  (per_len)
    );

    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        spi_tg_len #(.IS_BAUD(1'b0)) u_dly_len (
            .pre_i  (cfg_eff.d_pre[g]),
            .scl_i  (cfg_eff.d_scl[g]),
            .half_i (1'b0),
            .len_o  (dly_len[g])
        );
    end

    spi_tg_seq #(.FLEN_W(FLEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .flen_i    (frame_len),
        .cfg_i     (cfg_in),
        .per_len_i (per_len),
        .dly_len_i (dly_len),
        .cfg_eff_o (cfg_eff),
        .cfg_run_o (cfg_run),
        .sck_o     (sck),
        .cs_act_o  (cs_act),
        .busy_o    (busy),
        .lead_o    (lead_e),
        .trail_o   (trail_e),
        .done_o    (done)
    );

    spi_tg_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .lead_i   (lead_e),
        .trail_i  (trail_e),
        .cpha_i   (cfg_run.cpha),
        .smpl_i   (cfg_run.smpl),
        .shift_o  (shift_stb),
        .sample_o (sample_stb)
    );

    assign lead_done  = done[0];
    assign bits_done  = done[1];
    assign trail_done = done[2];
    assign gap_done   = done[3];

    p_cs_inside_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_act |-> busy);

    p_strobes_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> cs_act);

endmodule

// File: tb/spi_timing_gen_bench.sv
`timescale 1ns/1ps
module spi_timing_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] frame_len = '0;
    logic       cpol = 1'b0, cpha = 1'b0, dbr = 1'b0;
    logic [1:0] baud_pre = '0, lead_pre = '0, trail_pre = '0, gap_pre = '0, smpl_dly = '0;
    logic [3:0] baud_scl = '0, lead_scl = '0, trail_scl = '0, gap_scl = '0;
    logic sck, cs_act, busy, shift_stb, sample_stb;
    logic lead_done, bits_done, trail_done, gap_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int e_lead, e_trail, e_gap, e_per, e_hi, e_n, e_bits_end, e_tot, e_sd;
    bit e_cpha, e_cpol;

    always #2.5 clk = ~clk;

    spi_timing_gen u_spi_timing_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .cpol(cpol), .cpha(cpha), .dbr(dbr),
        .baud_pre(baud_pre), .baud_scl(baud_scl),
        .lead_pre(lead_pre), .lead_scl(lead_scl),
        .trail_pre(trail_pre), .trail_scl(trail_scl),
        .gap_pre(gap_pre), .gap_scl(gap_scl),
        .smpl_dly(smpl_dly),
        .sck(sck), .cs_act(cs_act), .busy(busy),
        .shift_stb(shift_stb), .sample_stb(sample_stb),
        .lead_done(lead_done), .bits_done(bits_done),
        .trail_done(trail_done), .gap_done(gap_done)
    );

    function automatic int bpre(input int c);
        return (c == 0) ? 2 : (c == 1) ? 3 : (c == 2) ? 5 : 7;
    endfunction

    function automatic int dpre(input int c);
        return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 5 : 7;
    endfunction

    function automatic bit lead_at(input int t);
        return (t >= e_lead) && (t < e_bits_end) && (((t - e_lead) % e_per) == 0);
    endfunction

    function automatic bit trail_at(input int t);
        return (t >= e_lead) && (t < e_bits_end) && (((t - e_lead) % e_per) == e_hi);
    endfunction

    function automatic bit cap_at(input int t);
        return e_cpha ? trail_at(t) : lead_at(t);
    endfunction

    task automatic check(input bit ok, input string req, input string detail);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    task automatic run_frame(input bit disturb);
        int eck, eseq, esh, esm, edn;
        string mck, mseq, msh, msm, mdn;
        logic [1:0] s_bp, s_sm; logic [3:0] s_bs, s_fl;
        eck = 0; eseq = 0; esh = 0; esm = 0; edn = 0;
        mck = ""; mseq = ""; msh = ""; msm = ""; mdn = "";
        e_per  = dbr ? (bpre(baud_pre) << baud_scl) : (bpre(baud_pre) << (baud_scl + 1));
        e_hi   = e_per / 2;
        e_lead = dpre(lead_pre) << (lead_scl + 1);
        e_trail = dpre(trail_pre) << (trail_scl + 1);
        e_gap  = dpre(gap_pre) << (gap_scl + 1);
        e_n    = int'(frame_len) + 1;
        e_bits_end = e_lead + e_n * e_per;
        e_tot  = e_bits_end + e_trail + e_gap;
        e_sd   = (smpl_dly == 2'd3) ? 0 : int'(smpl_dly);
        e_cpha = cpha; e_cpol = cpol;
        s_bp = baud_pre; s_bs = baud_scl; s_sm = smpl_dly; s_fl = frame_len;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t <= e_tot + 2; t++) begin
            bit in_bits, x_sck, x_cs, x_busy, x_sh, x_sm;
            logic [3:0] x_dn, a_dn;
            in_bits = (t >= e_lead) && (t < e_bits_end);
            x_sck  = e_cpol ^ (in_bits && (((t - e_lead) % e_per) < e_hi));
            x_cs   = t < e_bits_end + e_trail;
            x_busy = t < e_tot;
            x_sh   = e_cpha ? lead_at(t) : trail_at(t);
            x_sm   = (t - e_sd >= 0) ? cap_at(t - e_sd) : 1'b0;
            x_dn   = {t == e_tot, t == e_bits_end + e_trail, t == e_bits_end, t == e_lead};
            a_dn   = {gap_done, trail_done, bits_done, lead_done};
            if (sck !== x_sck) begin
                if (eck == 0) mck = $sformatf("t=%0d sck actual=%0b expected=%0b", t, sck, x_sck);
                eck++;
            end
            if ({cs_act, busy} !== {x_cs, x_busy}) begin
                if (eseq == 0) mseq = $sformatf("t=%0d cs/busy actual=%b%b expected=%b%b",
                                                t, cs_act, busy, x_cs, x_busy);
                eseq++;
            end
            if (shift_stb !== x_sh) begin
                if (esh == 0) msh = $sformatf("t=%0d shift actual=%0b expected=%0b", t, shift_stb, x_sh);
                esh++;
            end
            if (sample_stb !== x_sm) begin
                if (esm == 0) msm = $sformatf("t=%0d sample actual=%0b expected=%0b", t, sample_stb, x_sm);
                esm++;
            end
            if (a_dn !== x_dn) begin
                if (edn == 0) mdn = $sformatf("t=%0d done actual=%b expected=%b", t, a_dn, x_dn);
                edn++;
            end
            @(negedge clk);
            if (disturb && t == 1) begin
                start = 1'b1;
                baud_pre = ~baud_pre; baud_scl = baud_scl + 4'd1;
                smpl_dly = smpl_dly + 2'd1; frame_len = frame_len + 4'd2;
            end
            if (disturb && t == 2) start = 1'b0;
        end
        if (disturb) begin
            baud_pre = s_bp; baud_scl = s_bs; smpl_dly = s_sm; frame_len = s_fl;
            check(eck + eseq + esh + esm + edn == 0, "R9",
                  {mck, mseq, msh, msm, mdn, " actual=mismatch expected=unchanged frame"});
        end
        check(eck == 0, dbr ? "R2 R5" : "R1 R5", mck);
        check(eseq == 0, "R4 R10", mseq);
        check(esh == 0, "R6", msh);
        check(esm == 0, "R7", msm);
        check(edn == 0, "R3 R8", mdn);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(input int i);
        baud_pre  = 2'(i % 4);
        baud_scl  = 4'((i / 4) % 2);
        dbr       = 1'((i / 8) % 2);
        cpha      = 1'((i / 16) % 2);
        cpol      = 1'((i / 32) % 2);
        smpl_dly  = 2'((i / 64) % 4);
        lead_pre  = 2'((i / 2) % 4);
        lead_scl  = 4'((i / 3) % 2);
        trail_pre = 2'((i / 5) % 4);
        trail_scl = 4'((i / 7) % 2);
        gap_pre   = 2'((i / 11) % 4);
        gap_scl   = 4'((i / 13) % 2);
        frame_len = 4'(i % 3);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({sck, cs_act, busy, shift_stb, sample_stb} === 5'b0, "R11",
              $sformatf("in reset actual=%b expected=00000",
                        {sck, cs_act, busy, shift_stb, sample_stb}));
        rst_n = 1'b1;
        @(negedge clk);
        check({lead_done, bits_done, trail_done, gap_done, busy} === 5'b0, "R11",
              $sformatf("after reset actual=%b expected=00000",
                        {lead_done, bits_done, trail_done, gap_done, busy}));
        // near-exhaustive sweep of prescalers, double rate, edges and sample codes
        for (int i = 0; i < 256; i++) begin
            set_cfg(i);
            run_frame(1'b0);
        end
        // larger scalers and long frames (R1 R3 R10)
        set_cfg(5);
        baud_scl = 4'd2; lead_scl = 4'd3; trail_scl = 4'd2; gap_scl = 4'd3;
        frame_len = 4'd7; lead_pre = 2'd3;
        repeat (2) @(negedge clk);
        run_frame(1'b0);
        set_cfg(200);
        baud_scl = 4'd3; frame_len = 4'd15;
        repeat (2) @(negedge clk);
        run_frame(1'b0);
        // start and attribute changes during a frame (R9)
        for (int i = 0; i < 8; i++) begin
            set_cfg(i * 29 + 3);
            lead_scl = 4'd1;
            repeat (2) @(negedge clk);
            run_frame(1'b1);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule